// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It turns a 24-bit virtual address into a 32-bit physical address within the same cycle by comparing the page-number field of the address against every stored entry at once. Each entry carries a frame number, a four-bit flag field (dirty, referenced, writable, valid) and a process-id tag. The tag must equal the block's current process-id register for the entry to count as a match.

The block never walks page tables. An access whose page is not held raises a miss trap, and software then loads the missing entry through an indexed refill port. Software also chooses which slot is replaced. A store that reaches a read-only entry raises a protection fault. An allowed access marks its entry referenced, and an allowed store also marks it dirty. On a context switch, software can either clear every valid bit with one command or load a new process id, so that a new process misses until its own entries are present.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and the current process id is 0, so any lookup reports a miss.
- R2: The virtual page number is bits 23..13 of `lkVaddr`. On a hit, `lkPaddr` is the 19-bit frame number in bits 31..13 with `lkVaddr[12:0]` in bits 12..0. When there is no hit, `lkPaddr` and `lkFlags` are 0, and when `lkValid` is low all lookup outputs are 0.
- R3: An entry matches when its valid flag is set, its page number equals the address page number, and its process tag equals the current process id. The result appears combinationally in the same cycle as the request.
- R4: While `lkValid` is high, exactly one of `lkHit`, `lkMiss` and `lkProtFault` is high. `lkMiss` is reported when no entry matches.
- R5: When several entries match, the entry with the lowest index supplies the frame number and flags.
- R6: A store (`lkStore`=1) that matches an entry whose writable flag is 0 raises `lkProtFault` instead of a hit and leaves that entry's flags unchanged.
- R7: The flag field is {D,R,W,V} in bits 3..0. `lkFlags` returns the matching entry's flags as they were before the access. An allowed hit sets R in that entry at the next edge, and an allowed store also sets D.
- R8: A refill (`wrEn`) writes the page number, frame number, flags and process tag into slot `wrIdx` at the next clock edge, replacing whatever that slot held.
- R9: `flushAll` clears the valid flag of every entry at the next edge. A refill presented in the same cycle is still written and stays valid.
- R10: `pidWe` loads `pidIn` into the current process-id register at the next edge. Later lookups compare against the new id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkVaddr | input | 24 | Virtual address to translate |
| lkStore | input | 1 | 1 = store access, 0 = load |
| lkHit | output | 1 | Translation succeeded |
| lkMiss | output | 1 | Miss trap: no matching entry |
| lkProtFault | output | 1 | Store to an entry that is not writable |
| lkPaddr | output | 32 | Physical address on a hit, else 0 |
| lkFlags | output | 4 | Matching entry's flags {D,R,W,V} before this access, on a hit |
| wrEn | input | 1 | Refill write strobe |
| wrIdx | input | 6 | Slot to refill |
| wrVpn | input | 11 | Page number for the refilled slot |
| wrPfn | input | 19 | Frame number for the refilled slot |
| wrFlags | input | 4 | Flags {D,R,W,V} for the refilled slot |
| wrPid | input | 8 | Process tag for the refilled slot |
| flushAll | input | 1 | Clear every valid flag |
| pidWe | input | 1 | Load a new current process id |
| pidIn | input | 8 | New current process id |

## Verification
The hardest case to reach is a single cycle in which a flush and a refill land together, because the refilled slot has to survive while every other slot drops out. The stimulus drives both strobes in one cycle. It then shows that an entry written earlier under the same process id misses, and that the freshly refilled page hits with the frame number at the top of its range. A second hard case is the flag history of a single entry. A read-only page is stored to, then loaded twice, and the returned flags show that the fault left R clear and that only the first allowed access set it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Per-entry permission and state bits; bit order is {D,R,W,V} = 3..0
  typedef struct packed {
    logic d;
    logic r;
    logic w;
    logic v;
  } tlbFlags_t;

  // Strobes from control to the entry store
  typedef struct packed {
    logic setRef;
    logic setDirty;
    logic flush;
    logic refill;
    logic pidLoad;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       lkValid,
  input  logic       lkStore,
  input  logic       anyMatch,
  input  logic       matchWritable,
  input  logic       wrEn,
  input  logic       flushAll,
  input  logic       pidWe,
  output logic       lkHit,
  output logic       lkMiss,
  output logic       lkProtFault,
  output tlbStrobe_t stb
);

  logic storeDenied;

  always_comb begin
    storeDenied = lkStore & ~matchWritable;
    lkProtFault = lkValid & anyMatch & storeDenied;
    lkHit       = lkValid & anyMatch & ~storeDenied;
    lkMiss      = lkValid & ~anyMatch;

    stb          = '0;
    stb.setRef   = lkHit;
    stb.setDirty = lkHit & lkStore;
    stb.flush    = flushAll;
    stb.refill   = wrEn;
    stb.pidLoad  = pidWe;
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 11,
  parameter int PFN_W   = 19,
  parameter int PID_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lkVpn,
  input  tlbStrobe_t       stb,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PFN_W-1:0] wrPfn,
  input  tlbFlags_t        wrFlags,
  input  logic [PID_W-1:0] wrPid,
  input  logic [PID_W-1:0] pidIn,
  output logic             anyMatch,
  output logic [PFN_W-1:0] matchPfn,
  output tlbFlags_t        matchFlags
);

  logic [VPN_W-1:0] vpnQ   [ENTRIES];
  logic [PFN_W-1:0] pfnQ   [ENTRIES];
  logic [PID_W-1:0] pidQ   [ENTRIES];
  tlbFlags_t        flagsQ [ENTRIES];
  logic [PID_W-1:0] curPid;
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   hitIdx;

  // Parallel compare, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = flagsQ[g].v && (vpnQ[g] == lkVpn) && (pidQ[g] == curPid);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hitIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  assign anyMatch   = |matchVec;
  assign matchPfn   = pfnQ[hitIdx];
  assign matchFlags = flagsQ[hitIdx];

  // Flags and process id: reset, flush, access marking, then refill (last wins)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) flagsQ[i] <= '0;
      curPid <= '0;
    end else begin
      if (stb.flush) begin
        for (int i = 0; i < ENTRIES; i++) flagsQ[i].v <= 1'b0;
      end
      if (stb.setRef)   flagsQ[hitIdx].r <= 1'b1;
      if (stb.setDirty) flagsQ[hitIdx].d <= 1'b1;
      if (stb.refill)   flagsQ[wrIdx]    <= wrFlags;
      if (stb.pidLoad)  curPid           <= pidIn;
    end
  end

  // Key and payload fields need no reset: the cleared valid flag masks them
  always_ff @(posedge clk) begin
    if (stb.refill) begin
      vpnQ[wrIdx] <= wrVpn;
      pfnQ[wrIdx] <= wrPfn;
      pidQ[wrIdx] <= wrPid;
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int PID_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic [VA_W-1:0]  lkVaddr,
  input  logic             lkStore,
  output logic             lkHit,
  output logic             lkMiss,
  output logic             lkProtFault,
  output logic [PA_W-1:0]  lkPaddr,
  output logic [3:0]       lkFlags,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PFN_W-1:0] wrPfn,
  input  logic [3:0]       wrFlags,
  input  logic [PID_W-1:0] wrPid,
  input  logic             flushAll,
  input  logic             pidWe,
  input  logic [PID_W-1:0] pidIn
);

  tlbStrobe_t       stb;
  logic             anyMatch;
  logic [PFN_W-1:0] matchPfn;
  tlbFlags_t        matchFlags;

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .lkVpn     (lkVaddr[VA_W-1:OFF_W]),
    .stb       (stb),
    .wrIdx     (wrIdx),
    .wrVpn     (wrVpn),
    .wrPfn     (wrPfn),
    .wrFlags   (tlbFlags_t'(wrFlags)),
    .wrPid     (wrPid),
    .pidIn     (pidIn),
    .anyMatch  (anyMatch),
    .matchPfn  (matchPfn),
    .matchFlags(matchFlags)
  );

  tlb_ctrl u_ctrl (
    .lkValid      (lkValid),
    .lkStore      (lkStore),
    .anyMatch     (anyMatch),
    .matchWritable(matchFlags.w),
    .wrEn         (wrEn),
    .flushAll     (flushAll),
    .pidWe        (pidWe),
    .lkHit        (lkHit),
    .lkMiss       (lkMiss),
    .lkProtFault  (lkProtFault),
    .stb          (stb)
  );

  assign lkPaddr = lkHit ? {matchPfn, lkVaddr[OFF_W-1:0]} : '0;
  assign lkFlags = lkHit ? 4'(matchFlags) : 4'b0;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 24,
  parameter int PA_W  = 32,
  parameter int OFF_W = 13
) (
  input logic            clk,
  input logic            rstN,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic            lkStore,
  input logic            lkHit,
  input logic            lkMiss,
  input logic            lkProtFault,
  input logic [PA_W-1:0] lkPaddr,
  input logic [3:0]      lkFlags,
  input logic            wrEn,
  input logic            flushAll,
  input logic            pidWe
);

  logic pastOk;
  logic justReset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastOk    <= 1'b0;
      justReset <= 1'b1;
    end else begin
      pastOk    <= 1'b1;
      justReset <= 1'b0;
    end
  end

  AST_FIRST_LOOKUP_MISSES: assert property (@(posedge clk) disable iff (!rstN)
    (justReset && lkValid) |-> lkMiss); // R1

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkPaddr[OFF_W-1:0] == lkVaddr[OFF_W-1:0])); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |-> (!lkHit && !lkMiss && !lkProtFault && lkPaddr == '0)); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> $onehot({lkHit, lkMiss, lkProtFault})); // R4

  AST_FAULT_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    lkProtFault |-> lkStore); // R6

  AST_REF_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(lkHit) && lkHit && lkVaddr == $past(lkVaddr) &&
     !$past(wrEn) && !$past(flushAll) && !$past(pidWe)) |-> lkFlags[2]); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $past(flushAll) && !$past(wrEn) && lkValid) |-> lkMiss); // R9

endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkStore(lkStore),
  .lkHit(lkHit), .lkMiss(lkMiss), .lkProtFault(lkProtFault), .lkPaddr(lkPaddr),
  .lkFlags(lkFlags), .wrEn(wrEn), .flushAll(flushAll), .pidWe(pidWe)
);

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        lkValid;
  logic [23:0] lkVaddr;
  logic        lkStore;
  logic        lkHit, lkMiss, lkProtFault;
  logic [31:0] lkPaddr;
  logic [3:0]  lkFlags;
  logic        wrEn;
  logic [5:0]  wrIdx;
  logic [10:0] wrVpn;
  logic [18:0] wrPfn;
  logic [3:0]  wrFlags;
  logic [7:0]  wrPid;
  logic        flushAll;
  logic        pidWe;
  logic [7:0]  pidIn;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVaddr(lkVaddr), .lkStore(lkStore),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkProtFault(lkProtFault), .lkPaddr(lkPaddr),
    .lkFlags(lkFlags), .wrEn(wrEn), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrPfn(wrPfn),
    .wrFlags(wrFlags), .wrPid(wrPid), .flushAll(flushAll), .pidWe(pidWe), .pidIn(pidIn)
  );

  // Result codes: 0 miss, 1 hit, 2 protection fault, 3 none/illegal
  localparam logic [1:0] RMISS = 2'd0, RHIT = 2'd1, RFLT = 2'd2;

  typedef struct packed {
    logic        isWrite;
    logic [5:0]  idx;
    logic [10:0] vpn;
    logic [18:0] pfn;     // write: stored frame; lookup: expected frame
    logic [3:0]  flags;   // write: stored flags; lookup: expected returned flags
    logic [7:0]  pid;
    logic        store;
    logic [12:0] off;
    logic [1:0]  expRes;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 6'd0, 11'h050, 19'h02317, 4'b0011, 8'd0, 1'b0, 13'h0,    RMISS},
    '{1'b1, 6'd1, 11'h024, 19'h00092, 4'b0001, 8'd0, 1'b0, 13'h0,    RMISS},
    '{1'b1, 6'd2, 11'h019, 19'h0000C, 4'b0011, 8'd3, 1'b0, 13'h0,    RMISS},
    '{1'b1, 6'd5, 11'h006, 19'h00005, 4'b0011, 8'd0, 1'b0, 13'h0,    RMISS},
    '{1'b1, 6'd7, 11'h006, 19'h00025, 4'b0011, 8'd0, 1'b0, 13'h0,    RMISS},
    '{1'b0, 6'd0, 11'h050, 19'h02317, 4'b0011, 8'd0, 1'b0, 13'h1ABC, RHIT},  // R3 fresh flags
    '{1'b0, 6'd0, 11'h050, 19'h02317, 4'b0111, 8'd0, 1'b1, 13'h0000, RHIT},  // R7 R set
    '{1'b0, 6'd0, 11'h050, 19'h02317, 4'b1111, 8'd0, 1'b0, 13'h1FFF, RHIT},  // R7 D set
    '{1'b0, 6'd0, 11'h024, 19'h00000, 4'b0000, 8'd0, 1'b1, 13'h0123, RFLT},  // R6
    '{1'b0, 6'd0, 11'h024, 19'h00092, 4'b0001, 8'd0, 1'b0, 13'h0123, RHIT},  // R6 no mark
    '{1'b0, 6'd0, 11'h024, 19'h00092, 4'b0101, 8'd0, 1'b0, 13'h0004, RHIT},  // R7
    '{1'b0, 6'd0, 11'h019, 19'h00000, 4'b0000, 8'd0, 1'b0, 13'h0000, RMISS}, // R3 pid mismatch
    '{1'b0, 6'd0, 11'h006, 19'h00005, 4'b0011, 8'd0, 1'b0, 13'h0ACE, RHIT},  // R5 lowest wins
    '{1'b0, 6'd0, 11'h033, 19'h00000, 4'b0000, 8'd0, 1'b0, 13'h0000, RMISS}  // R4 no entry
  };

  function automatic logic [1:0] resCode();
    if (lkHit && !lkMiss && !lkProtFault) return RHIT;
    if (lkMiss && !lkHit && !lkProtFault) return RMISS;
    if (lkProtFault && !lkHit && !lkMiss) return RFLT;
    return 2'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lkValid = 0; lkVaddr = '0; lkStore = 0;
    wrEn = 0; wrIdx = '0; wrVpn = '0; wrPfn = '0; wrFlags = '0; wrPid = '0;
    flushAll = 0; pidWe = 0; pidIn = '0;
  endtask

  // Drive a lookup at the falling edge and check it before the rising edge
  task automatic lookup(input logic [10:0] vpn, input logic [12:0] off, input logic st,
                        input logic [1:0] expRes, input logic [18:0] expPfn,
                        input logic [3:0] expFl, input string req);
    @(negedge clk);
    idle();
    lkValid = 1; lkVaddr = {vpn, off}; lkStore = st;
    #1;
    chk(resCode() == expRes, req, 64'(resCode()), 64'(expRes));
    if (expRes == RHIT) begin
      chk(lkPaddr == {expPfn, off}, req, 64'(lkPaddr), 64'({expPfn, off}));
      chk(lkFlags == expFl, req, 64'(lkFlags), 64'(expFl));
    end else begin
      chk(lkPaddr == 32'h0, req, 64'(lkPaddr), 64'h0);
    end
  endtask

  task automatic refill(input logic [5:0] idx, input logic [10:0] vpn, input logic [18:0] pfn,
                        input logic [3:0] fl, input logic [7:0] pid);
    @(negedge clk);
    idle();
    wrEn = 1; wrIdx = idx; wrVpn = vpn; wrPfn = pfn; wrFlags = fl; wrPid = pid;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: nothing valid after reset
    lookup(11'h050, 13'h0010, 1'b0, RMISS, '0, '0, "R1 reset empty");
    lookup(11'h000, 13'h0000, 1'b0, RMISS, '0, '0, "R1 reset empty vpn0 pid0");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWrite) begin
        refill(VEC[i].idx, VEC[i].vpn, VEC[i].pfn, VEC[i].flags, VEC[i].pid);  // R8
      end else begin
        lookup(VEC[i].vpn, VEC[i].off, VEC[i].store, VEC[i].expRes, VEC[i].pfn,
               VEC[i].flags, $sformatf("R3/R4/R5/R6/R7 vector %0d", i));
      end
    end

    // R2: idle lookup port gives all-zero outputs
    @(negedge clk);
    idle();
    lkVaddr = {11'h050, 13'h0055};
    #1;
    chk({lkHit, lkMiss, lkProtFault} == 3'b000 && lkPaddr == 0 && lkFlags == 0,
        "R2 idle quiet", 64'({lkHit, lkMiss, lkProtFault, lkPaddr}), 64'h0);

    // R8 + R5: invalidate slot 5 by overwrite, slot 7 now answers
    refill(6'd5, 11'h006, 19'h00005, 4'b0000, 8'd0);
    lookup(11'h006, 13'h0001, 1'b0, RHIT, 19'h00025, 4'b0011, "R8 overwrite / R5 next slot");

    // R10: switch process id to 3
    @(negedge clk);
    idle();
    pidWe = 1; pidIn = 8'd3;
    lookup(11'h019, 13'h1000, 1'b0, RHIT, 19'h0000C, 4'b0011, "R10 new pid hits");
    lookup(11'h050, 13'h0000, 1'b0, RMISS, '0, '0, "R10 old pid misses");

    // R9: flush and refill in the same cycle
    @(negedge clk);
    idle();
    flushAll = 1;
    wrEn = 1; wrIdx = 6'd9; wrVpn = 11'h100; wrPfn = 19'h7FFFF; wrFlags = 4'b0011; wrPid = 8'd3;
    lookup(11'h019, 13'h0000, 1'b0, RMISS, '0, '0, "R9 flushed entry misses");
    lookup(11'h100, 13'h1FFF, 1'b0, RHIT, 19'h7FFFF, 4'b0011, "R9 same-cycle refill survives");

    @(negedge clk);
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule